// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial EEPROM holding 256 bytes. A system clock oversamples the SCL and SDA lines through a synchronizer and detects start and stop conditions. The first byte after a start selects the device: a fixed 4-bit prefix, three strap inputs and a direction bit. The bus master writes by sending a word address and then data bytes. These bytes collect in an 8-byte page buffer. After the master's stop, a write cycle commits the buffer to the array. The write cycle lasts a parameterized number of system clocks. While it runs, the block ignores the bus and `busy_o` is high. A master can therefore poll with repeated device-address bytes until one is acknowledged. Reads are current-address reads: the block returns the byte at its internal pointer and then advances the pointer. SDA is driven as an open-drain output enable: `sda_oe_o` high pulls the line low.

The controller is one state machine with these states:
- `S_IDLE`: waits for a start.
- `S_DEV`: shifts in the device byte. On a match it goes to `S_DEV_ACK`; on a mismatch it goes to `S_IDLE`.
- `S_DEV_ACK`: drives the acknowledge. It then goes to `S_RDATA` for a read or to `S_WADDR` for a write.
- `S_WADDR` then `S_WADDR_ACK`: the word address and its acknowledge. The block then moves to `S_WDATA`.
- `S_WDATA` and `S_WDATA_ACK`: alternate for each data byte.
- `S_RDATA`: shifts a byte out. It moves to `S_RD_ACK`, which samples the master's answer. An acknowledge returns to `S_RDATA`; a not-acknowledge goes to `S_IDLE`.
- `S_BUSY`: the write cycle. It returns to `S_IDLE` when its counter expires.

Transitions common to all states except `S_BUSY`:
- A start in any such state goes to `S_DEV`.
- A stop goes to `S_BUSY` when page data is buffered, and to `S_IDLE` otherwise.

Top module: `twi_eep_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `busy_o` are low, and every array byte reads 0xFF.
- R2: The device byte is sent MSB first and holds the prefix 1010 in bits 7..4, the strap inputs in bits 3..1 and the direction in bit 0 (1 = read, 0 = write). On a match the block pulls SDA low in the ninth clock. On a mismatch it gives no acknowledge and ignores all further bytes until the next start.
- R3: In a write, the word address byte and every following data byte are each acknowledged with a low ninth bit.
- R4: Each data byte goes to the buffer slot named by the low three pointer bits. Those bits then increment modulo 8 while the upper five bits stay fixed. A ninth byte therefore overwrites the first slot used.
- R5: A stop with at least one buffered data byte raises `busy_o` for exactly TWR_CYCLES system clocks. Only the bytes received are written; other bytes of the page keep their values.
- R6: While `busy_o` is high, no acknowledge is given, even for a matching device byte of either direction.
- R7: After `busy_o` falls, a matching device byte is acknowledged again.
- R8: A stop that follows a word address but no data byte starts no write cycle and changes no array byte; it does load the pointer.
- R9: A read returns the byte at the pointer MSB first and then increments the pointer by one. A master acknowledge (SDA low) continues with the next byte. A not-acknowledge leaves SDA released.
- R10: After a write, the pointer holds the address that follows the last stored byte, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Device select straps compared with device byte bits 3..1 |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
A wrong state or a wrong bit count shows up within one byte time as an acknowledge in the wrong clock or a missing one. Both appear on `sda_oe_o` at the master's ninth-bit sample. A corrupted pointer or page buffer stays hidden until the data is read back. The bench therefore ends each write with reads whose expected bytes depend on the page wrap and on the last written slot. A wrong write-cycle length or a missed commit shows at once as the duration of `busy_o` and as the outcome of the first poll.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
    localparam int         SEL_W      = 3;
    localparam int         BYTE_W     = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RD_ACK,
        S_BUSY
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s   = scl_sh[STAGES-1];
    assign sda_s   = sda_sh[STAGES-1];
    assign sda_o   = sda_s;
    assign start_o = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
    assign rise_o  = scl_s & ~scl_q;
    assign fall_o  = ~scl_s & scl_q;

endmodule

// File: rtl/twi_eep_array.sv
module twi_eep_array #(
    parameter int          ADDR_W = 8,
    parameter int          PAGE_W = 3,
    parameter logic [7:0]  ERASED = 8'hFF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]       page_i,
    input  logic [(1<<PAGE_W)-1:0]         mask_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]    data_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    output logic [7:0]                     rd_data_o
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (commit_i) begin
            for (int j = 0; j < PAGE_N; j++) begin
                if (mask_i[j]) mem[{page_i, PAGE_W'(j)}] <= data_i[j];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/twi_eep_slave.sv
module twi_eep_slave
    import twi_eep_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_W     = 3,
    parameter int TWR_CYCLES = 250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] strap_i,
    output logic             sda_oe_o,
    output logic             busy_o
);

    localparam int PAGE_N = 1 << PAGE_W;
    localparam int HI_W   = ADDR_W - PAGE_W;
    localparam int TWR_W  = $clog2(TWR_CYCLES + 1);

    twi_state_e state, nxt;

    logic                        sda_s, start_ev, stop_ev, rise_ev, fall_ev;
    logic [3:0]                  bit_cnt;
    logic [BYTE_W-1:0]           rx_q;
    logic [BYTE_W-1:0]           tx_q;
    logic                        rw_q;
    logic                        mack_q;
    logic [ADDR_W-1:0]           ptr_q;
    logic [PAGE_N-1:0][7:0]      pbuf;
    logic [PAGE_N-1:0]           pmask;
    logic [TWR_W-1:0]            twr_cnt;
    logic [7:0]                  rd_data;
    logic                        byte_done, dev_match, has_data;
    logic                        data_stb, commit, bus_live;

    twi_line_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_o   (sda_s),
        .start_o (start_ev),
        .stop_o  (stop_ev),
        .rise_o  (rise_ev),
        .fall_o  (fall_ev)
    );

    twi_eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (ptr_q[ADDR_W-1:PAGE_W]),
        .mask_i    (pmask),
        .data_i    (pbuf),
        .rd_addr_i (ptr_q),
        .rd_data_o (rd_data)
    );

    assign bus_live  = (state != S_BUSY);
    assign byte_done = fall_ev && (bit_cnt == 4'd8);
    assign dev_match = (rx_q[7:4] == DEV_PREFIX) && (rx_q[3:1] == strap_i);
    assign has_data  = |pmask;
    assign data_stb  = (state == S_WDATA) && byte_done;
    assign commit    = bus_live && stop_ev && has_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (bus_live && start_ev) begin
            nxt = S_DEV;
        end else if (bus_live && stop_ev) begin
            nxt = has_data ? S_BUSY : S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_DEV:       if (byte_done) nxt = dev_match ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:   if (fall_ev)   nxt = rw_q ? S_RDATA : S_WADDR;
                S_WADDR:     if (byte_done) nxt = S_WADDR_ACK;
                S_WADDR_ACK: if (fall_ev)   nxt = S_WDATA;
                S_WDATA:     if (byte_done) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (fall_ev)   nxt = S_WDATA;
                S_RDATA:     if (fall_ev && bit_cnt == 4'd7) nxt = S_RD_ACK;
                S_RD_ACK:    if (fall_ev)   nxt = mack_q ? S_RDATA : S_IDLE;
                S_BUSY:      if (twr_cnt == '0) nxt = S_IDLE;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            ptr_q   <= '0;
            pbuf    <= '0;
            pmask   <= '0;
            twr_cnt <= '0;
        end else begin
            unique case (state)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (rise_ev) begin
                        rx_q    <= {rx_q[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        if (state == S_DEV)   rw_q  <= rx_q[0];
                        if (state == S_WADDR) ptr_q <= rx_q;
                        if (state == S_WDATA) begin
                            pbuf[ptr_q[PAGE_W-1:0]]  <= rx_q;
                            pmask[ptr_q[PAGE_W-1:0]] <= 1'b1;
                            ptr_q[PAGE_W-1:0]        <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (fall_ev) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx_q  <= rd_data;
                            ptr_q <= ptr_q + ADDR_W'(1);
                        end
                    end
                end
                S_WADDR_ACK, S_WDATA_ACK: begin
                    if (fall_ev) bit_cnt <= '0;
                end
                S_RDATA: begin
                    if (fall_ev) begin
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                        end else begin
                            tx_q    <= {tx_q[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                S_RD_ACK: begin
                    if (rise_ev) mack_q <= ~sda_s;
                    if (fall_ev && mack_q) begin
                        tx_q  <= rd_data;
                        ptr_q <= ptr_q + ADDR_W'(1);
                    end
                end
                S_BUSY: begin
                    if (twr_cnt != '0) twr_cnt <= twr_cnt - TWR_W'(1);
                end
                default: ;
            endcase
            if (bus_live && start_ev) begin
                bit_cnt <= '0;
                pmask   <= '0;
            end else if (commit) begin
                pmask   <= '0;
                twr_cnt <= TWR_W'(TWR_CYCLES - 1);
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        busy_o   = 1'b0;
        unique case (state)
            S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: sda_oe_o = 1'b1;
            S_RDATA:                             sda_oe_o = ~tx_q[7];
            S_BUSY:                              busy_o   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/twi_eep_chk.sv
module twi_eep_chk #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3,
    parameter int TWR    = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              sda_oe_o,
    input logic              stop_ev,
    input logic              data_stb,
    input logic [ADDR_W-1:0] ptr_q
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_q == TWR);

    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_ev));

    p_silent_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));

    p_low_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> ptr_q[PAGE_W-1:0] == PAGE_W'($past(ptr_q[PAGE_W-1:0]) + 1'b1));

endmodule

bind twi_eep_slave twi_eep_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .TWR    (TWR_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .sda_oe_o (sda_oe_o),
    .stop_ev  (stop_ev),
    .data_stb (data_stb),
    .ptr_q    (ptr_q)
);

// File: tb/twi_eep_slave_test.sv
module twi_eep_slave_test;

    localparam int         TWR   = 1500;
    localparam int         Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy;
    logic sda_line;
    int   total = 0;
    int   bad = 0;
    int   run = 0;
    int   last_len = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_eep_slave #(.TWR_CYCLES(TWR)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe),
        .busy_o   (busy)
    );

    always @(negedge clk) begin
        if (!rst_n) run = 0;
        else if (busy) run = run + 1;
        else if (run != 0) begin
            last_len = run;
            run = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b1; q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q_wait();
            scl_m = 1'b1; q_wait(); q_wait();
            scl_m = 1'b0; q_wait();
        end
        sda_m = 1'b1; q_wait();
        scl_m = 1'b1; q_wait();
        ack = ~sda_line; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q_wait();
            scl_m = 1'b1; q_wait();
            b[i] = sda_line; q_wait();
            scl_m = 1'b0;
        end
        q_wait();
        sda_m = ~give_ack; q_wait();
        scl_m = 1'b1; q_wait(); q_wait();
        scl_m = 1'b0; q_wait();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] waddr, input int n);
        logic a;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a);
        chk("R2 device ack", a, 1);
        send_byte(waddr, a);
        chk("R3 word address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk("R3 data ack", a, 1);
        end
        bus_stop();
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        q_wait();
    endtask

    task automatic set_ptr(input logic [7:0] waddr);
        do_write(waddr, 0);
        q_wait();
        chk("R8 no write cycle", busy, 0);
    endtask

    task automatic cur_read(input int n);
        logic a;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, a);
        chk("R9 read device ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        chk("R9 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 sda_oe reset", sda_oe, 0);
        chk("R1 busy reset", busy, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, a);
        chk("R2 bad prefix nack", a, 0);
        send_byte(8'h00, a);
        chk("R2 ignored after mismatch", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, a);
        chk("R2 bad strap nack", a, 0);
        bus_stop();
        chk("R2 no busy", busy, 0);
    endtask

    task automatic t_write_poll();
        logic a;
        int polls;
        wbuf[0] = 8'hA5;
        do_write(8'h12, 1);
        chk("R5 busy after stop", busy, 1);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a);
        chk("R6 write poll nack", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, a);
        chk("R6 read poll nack", a, 0);
        bus_stop();
        a = 1'b0;
        polls = 0;
        while (!a && polls < 40) begin
            bus_start();
            send_byte({4'b1010, STRAP, 1'b0}, a);
            polls++;
            if (!a) bus_stop();
        end
        chk("R7 poll acked", a, 1);
        chk("R7 busy low at ack", busy, 0);
        bus_stop();
        q_wait();
        chk("R5 busy length", last_len, TWR);
    endtask

    task automatic t_read_back();
        set_ptr(8'h12);
        cur_read(2);
        chk("R9 byte at pointer", rbuf[0], 8'hA5);
        chk("R5 untouched neighbour", rbuf[1], 8'hFF);
        cur_read(1);
        chk("R9 pointer advanced", rbuf[0], 8'hFF);
    endtask

    task automatic t_page_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(8'h2E, 4);
        wait_idle();
        set_ptr(8'h28);
        cur_read(8);
        chk("R4 wrap slot 0", rbuf[0], 8'h33);
        chk("R4 wrap slot 1", rbuf[1], 8'h44);
        chk("R5 slot 2 kept", rbuf[2], 8'hFF);
        chk("R4 slot 6", rbuf[6], 8'h11);
        chk("R4 slot 7", rbuf[7], 8'h22);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 10; i++) wbuf[i] = 8'h80 + 8'(i);
        do_write(8'h40, 10);
        wait_idle();
        cur_read(1);
        chk("R10 pointer after write", rbuf[0], 8'h82);
        set_ptr(8'h40);
        cur_read(8);
        chk("R4 overwrite slot 0", rbuf[0], 8'h88);
        chk("R4 overwrite slot 1", rbuf[1], 8'h89);
        for (int i = 2; i < 8; i++) chk("R4 kept slot", rbuf[i], 8'h80 + 8'(i));
        cur_read(1);
        chk("R4 next page untouched", rbuf[0], 8'hFF);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_mismatch();
        t_write_poll();
        t_read_back();
        t_page_wrap();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule